// File: doc/BRIEF.md
# Ring Command Queue Parser

This block drains a stream of 32-bit command words that a host producer places in a circular queue in shared memory. The first four words of that memory region form a header of byte offsets: the lower wrap bound, the upper bound, the producer position and the consumer position. When the block is both configured and enabled, it loads the bounds and the consumer position from the header. It then keeps polling the producer position, and whenever unread words exist it fetches an opcode and the argument words that belong to it.

Opcodes with a known shape are handed to a rendering engine as one decoded command carrying up to six arguments. A cursor definition also carries a trailer of mask and image words, whose length comes from its own width, height and depth arguments. That trailer is read past and is not forwarded. Opcodes that are recognised but not supported are read past in full, so the consumer position stays aligned with command boundaries. An opcode that is not recognised stops the parser and raises an error flag. After each command is finished, the block writes the consumer position back into the header, so the producer can see how much space it has.

Top module: `cmdring_parser`

## Requirements
- R1: After reset, cmd_valid, mem_req and parse_err are all low.
- R2: While cfg_done and cfg_enable are not both high, the queue is treated as empty: no opcode is read and no command is emitted. From reset with either input low, mem_req stays low.
- R3: When the producer word (header word 2) equals the consumer position, no command is emitted and header word 3 is not written.
- R4: Each queue read fetches word address stop/4 and then adds 4 to stop. If the result is greater than or equal to the upper bound (header word 1), stop becomes the lower bound (header word 0). A pending mem_req holds its address and direction until mem_ack.
- R5: Opcodes 1 and 25 are emitted with cmd_argc = 4 and the arguments x, y, width, height.
- R6: Opcode 2 is emitted with 5 arguments (colour, x, y, width, height). Opcode 3 is emitted with 6 arguments (source x, source y, destination x, destination y, width, height).
- R7: Opcode 19 is emitted with 6 arguments (id, hot x, hot y, width w, height h, depth d). It is then followed by ((w+31)>>5)*h + ((w*d+31)>>5)*h trailer words, which are consumed and not emitted.
- R8: Opcode 13 (followed by 6 words) and opcode 14 (followed by 7 words) are consumed without being emitted.
- R9: Any other opcode sets parse_err. After that, no command is emitted, no memory access is made and header word 3 is left unchanged, until cfg_done and cfg_enable are dropped and raised again. That re-enable clears parse_err and reloads the header.
- R10: After every completed command, whether it was emitted or skipped, the consumer position is written to header word 3. Header word 3 is the only word ever written.
- R11: Once cmd_valid rises, it stays high with cmd_op, cmd_argc and cmd_args unchanged until a cycle in which cmd_ready is high. Parsing stalls during that time. Argument i sits at cmd_args[32*i+31:32*i], and unused slots read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_done | input | 1 | Queue memory has been configured |
| cfg_enable | input | 1 | Parser enabled |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write (header write-back) |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 32 | Write data (consumer position) |
| mem_ack | input | 1 | Access completed; read data valid |
| mem_rdata | input | 32 | Read data |
| cmd_valid | output | 1 | Decoded command available |
| cmd_ready | input | 1 | Downstream accepts the command |
| cmd_op | output | 8 | Opcode of the command |
| cmd_argc | output | 4 | Number of meaningful argument slots |
| cmd_args | output | 192 | Argument slots, slot i at bits 32*i+31:32*i |
| parse_err | output | 1 | Unrecognised opcode seen |

## Verification
The case that needs the most care is the consumer position wrapping on the same read that completes a command. In that cycle the pointer wrap and the command hand-off, followed by the write-back, happen together. The bench reloads the header so that a four-argument update ends exactly on the upper bound. It then expects the written-back position to be the lower bound, and expects the next command, fetched from that lower bound, to arrive intact. A second overlap, a cursor trailer that runs across the wrap, is judged by whether the update placed right after it decodes correctly.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

    localparam int WORD_W   = 32;
    localparam int MAX_ARGS = 6;
    localparam int CNT_W    = 4;

    localparam int HDR_LO   = 0;
    localparam int HDR_HI   = 1;
    localparam int HDR_PROD = 2;
    localparam int HDR_CONS = 3;

    localparam logic [WORD_W-1:0] OPC_UPDATE   = 32'd1;
    localparam logic [WORD_W-1:0] OPC_FILL     = 32'd2;
    localparam logic [WORD_W-1:0] OPC_COPY     = 32'd3;
    localparam logic [WORD_W-1:0] OPC_ROP_FILL = 32'd13;
    localparam logic [WORD_W-1:0] OPC_ROP_COPY = 32'd14;
    localparam logic [WORD_W-1:0] OPC_CURSOR   = 32'd19;
    localparam logic [WORD_W-1:0] OPC_UPDATE_V = 32'd25;

    typedef enum logic [3:0] {
        S_IDLE, S_HLO, S_HHI, S_HCONS, S_POLL, S_OP,
        S_ARG, S_CALC, S_DATA, S_ISSUE, S_WB, S_ERR
    } pstate_t;

    typedef enum logic [1:0] {
        K_UNKNOWN, K_EMIT, K_SKIP, K_CURSOR
    } kind_t;

    typedef struct packed {
        kind_t            kind;
        logic [CNT_W-1:0] nargs;
    } opinfo_t;

    function automatic opinfo_t classify(input logic [WORD_W-1:0] op);
        opinfo_t r;
        r.kind  = K_UNKNOWN;
        r.nargs = '0;
        case (op)
            OPC_UPDATE, OPC_UPDATE_V: begin r.kind = K_EMIT;   r.nargs = 4'd4; end
            OPC_FILL:                 begin r.kind = K_EMIT;   r.nargs = 4'd5; end
            OPC_COPY:                 begin r.kind = K_EMIT;   r.nargs = 4'd6; end
            OPC_CURSOR:               begin r.kind = K_CURSOR; r.nargs = 4'd6; end
            OPC_ROP_FILL:             begin r.kind = K_SKIP;   r.nargs = 4'd6; end
            OPC_ROP_COPY:             begin r.kind = K_SKIP;   r.nargs = 4'd7; end
            default:                  begin r.kind = K_UNKNOWN; r.nargs = 4'd0; end
        endcase
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] cursor_trailer(
        input logic [WORD_W-1:0] w,
        input logic [WORD_W-1:0] h,
        input logic [WORD_W-1:0] d);
        logic [WORD_W-1:0] mask_row;
        logic [WORD_W-1:0] img_row;
        mask_row = (w + 32'd31) >> 5;
        img_row  = ((w * d) + 32'd31) >> 5;
        return (mask_row * h) + (img_row * h);
    endfunction

endpackage

// File: rtl/cmdq_decode.sv
module cmdq_decode
    import cmdq_pkg::*;
(
    input  logic [WORD_W-1:0] op_word,
    output kind_t             kind,
    output logic [CNT_W-1:0]  nargs
);
    opinfo_t info;

    always_comb begin
        info  = classify(op_word);
        kind  = info.kind;
        nargs = info.nargs;
    end
endmodule

// File: rtl/cmdq_ptr.sv
module cmdq_ptr
    import cmdq_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic              ld_cons,
    input  logic              adv,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] cons,
    output logic [ADDR_W-1:0] cons_waddr
);
    logic [WORD_W-1:0] lo_q;
    logic [WORD_W-1:0] hi_q;
    logic [WORD_W-1:0] cons_q;
    logic [WORD_W-1:0] step;
    logic [WORD_W-1:0] stepped;

    always_comb begin
        step    = cons_q + 32'd4;
        stepped = (step >= hi_q) ? lo_q : step;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q   <= '0;
            hi_q   <= '0;
            cons_q <= '0;
        end else begin
            if (ld_lo) lo_q <= din;
            if (ld_hi) hi_q <= din;
            if (ld_cons)  cons_q <= din;
            else if (adv) cons_q <= stepped;
        end
    end

    assign cons       = cons_q;
    assign cons_waddr = cons_q[ADDR_W+1:2];
endmodule

// File: rtl/cmdq_argbuf.sv
module cmdq_argbuf
    import cmdq_pkg::*;
#(
    parameter int SLOTS = MAX_ARGS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    wr,
    input  logic [CNT_W-1:0]        idx,
    input  logic [WORD_W-1:0]       din,
    output logic [SLOTS*WORD_W-1:0] flat
);
    genvar g;
    generate
        for (g = 0; g < SLOTS; g++) begin : g_slot
            logic [WORD_W-1:0] slot_q;
            always_ff @(posedge clk) begin
                if (rst || clr)
                    slot_q <= '0;
                else if (wr && (idx == CNT_W'(g)))
                    slot_q <= din;
            end
            assign flat[g*WORD_W +: WORD_W] = slot_q;
        end
    endgenerate
endmodule

// File: rtl/cmdring_parser.sv
module cmdring_parser
    import cmdq_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_done,
    input  logic                       cfg_enable,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [WORD_W-1:0]          mem_wdata,
    input  logic                       mem_ack,
    input  logic [WORD_W-1:0]          mem_rdata,
    output logic                       cmd_valid,
    input  logic                       cmd_ready,
    output logic [7:0]                 cmd_op,
    output logic [CNT_W-1:0]           cmd_argc,
    output logic [MAX_ARGS*WORD_W-1:0] cmd_args,
    output logic                       parse_err
);
    pstate_t           state;
    logic              cfg_ok;
    logic [7:0]        op_q;
    kind_t             kind_q;
    logic [CNT_W-1:0]  nargs_q;
    logic [CNT_W-1:0]  arg_idx;
    logic [WORD_W-1:0] trail_left;
    logic              err_q;

    kind_t             dec_kind;
    logic [CNT_W-1:0]  dec_nargs;
    logic [WORD_W-1:0] cons;
    logic [ADDR_W-1:0] cons_waddr;
    logic [WORD_W-1:0] trail_len;
    logic              ld_lo, ld_hi, ld_cons, adv;
    logic              buf_clr, buf_wr;
    logic              last_arg;

    assign cfg_ok = cfg_done && cfg_enable;

    cmdq_decode u_dec (
        .op_word (mem_rdata),
        .kind    (dec_kind),
        .nargs   (dec_nargs)
    );

    cmdq_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk        (clk),
        .rst        (rst),
        .ld_lo      (ld_lo),
        .ld_hi      (ld_hi),
        .ld_cons    (ld_cons),
        .adv        (adv),
        .din        (mem_rdata),
        .cons       (cons),
        .cons_waddr (cons_waddr)
    );

    cmdq_argbuf #(.SLOTS(MAX_ARGS)) u_args (
        .clk  (clk),
        .rst  (rst),
        .clr  (buf_clr),
        .wr   (buf_wr),
        .idx  (arg_idx),
        .din  (mem_rdata),
        .flat (cmd_args)
    );

    always_comb begin
        mem_req = 1'b0;
        mem_we  = 1'b0;
        case (state)
            S_HLO:   mem_addr = ADDR_W'(HDR_LO);
            S_HHI:   mem_addr = ADDR_W'(HDR_HI);
            S_HCONS: mem_addr = ADDR_W'(HDR_CONS);
            S_POLL:  mem_addr = ADDR_W'(HDR_PROD);
            S_WB:    mem_addr = ADDR_W'(HDR_CONS);
            default: mem_addr = cons_waddr;
        endcase
        case (state)
            S_HLO, S_HHI, S_HCONS, S_POLL, S_OP, S_ARG, S_DATA: mem_req = 1'b1;
            S_WB: begin mem_req = 1'b1; mem_we = 1'b1; end
            default: ;
        endcase
    end

    assign mem_wdata = cons;
    assign ld_lo     = (state == S_HLO)   && mem_ack;
    assign ld_hi     = (state == S_HHI)   && mem_ack;
    assign ld_cons   = (state == S_HCONS) && mem_ack;
    assign adv       = mem_ack && ((state == S_OP) || (state == S_ARG) || (state == S_DATA));
    assign buf_clr   = (state == S_OP)  && mem_ack;
    assign buf_wr    = (state == S_ARG) && mem_ack;
    assign last_arg  = (arg_idx == nargs_q - CNT_W'(1));
    assign trail_len = cursor_trailer(cmd_args[3*WORD_W +: WORD_W],
                                      cmd_args[4*WORD_W +: WORD_W],
                                      cmd_args[5*WORD_W +: WORD_W]);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            op_q       <= '0;
            kind_q     <= K_UNKNOWN;
            nargs_q    <= '0;
            arg_idx    <= '0;
            trail_left <= '0;
            err_q      <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (cfg_ok) begin
                    err_q <= 1'b0;
                    state <= S_HLO;
                end
                S_HLO:   if (mem_ack) state <= S_HHI;
                S_HHI:   if (mem_ack) state <= S_HCONS;
                S_HCONS: if (mem_ack) state <= S_POLL;
                S_POLL: if (mem_ack) begin
                    if (!cfg_ok)               state <= S_IDLE;
                    else if (mem_rdata != cons) state <= S_OP;
                end
                S_OP: if (mem_ack) begin
                    op_q    <= mem_rdata[7:0];
                    kind_q  <= dec_kind;
                    nargs_q <= dec_nargs;
                    arg_idx <= '0;
                    if (dec_kind == K_UNKNOWN) begin
                        err_q <= 1'b1;
                        state <= S_ERR;
                    end else begin
                        state <= S_ARG;
                    end
                end
                S_ARG: if (mem_ack) begin
                    arg_idx <= arg_idx + CNT_W'(1);
                    if (last_arg) begin
                        case (kind_q)
                            K_EMIT:   state <= S_ISSUE;
                            K_CURSOR: state <= S_CALC;
                            default:  state <= S_WB;
                        endcase
                    end
                end
                S_CALC: begin
                    trail_left <= trail_len;
                    state      <= (trail_len == '0) ? S_ISSUE : S_DATA;
                end
                S_DATA: if (mem_ack) begin
                    trail_left <= trail_left - 32'd1;
                    if (trail_left == 32'd1) state <= S_ISSUE;
                end
                S_ISSUE: if (cmd_ready) state <= S_WB;
                S_WB:    if (mem_ack) state <= S_POLL;
                S_ERR:   if (!cfg_ok) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign cmd_valid = (state == S_ISSUE);
    assign cmd_op    = op_q;
    assign cmd_argc  = nargs_q;
    assign parse_err = err_q;
endmodule

// File: rtl/cmdq_checker.sv
module cmdq_checker
    import cmdq_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       mem_req,
    input logic                       mem_we,
    input logic [ADDR_W-1:0]          mem_addr,
    input logic                       mem_ack,
    input logic                       cmd_valid,
    input logic                       cmd_ready,
    input logic [7:0]                 cmd_op,
    input logic [CNT_W-1:0]           cmd_argc,
    input logic [MAX_ARGS*WORD_W-1:0] cmd_args,
    input logic                       parse_err
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!cmd_valid && !mem_req && !parse_err)); // R1

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R4

    AST_UPDATE_ARGC: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_op == 8'd1 || cmd_op == 8'd25)) |-> (cmd_argc == 4'd4)); // R5

    AST_RECT_ARGC: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> ((cmd_op != 8'd2 || cmd_argc == 4'd5) &&
                       (cmd_op != 8'd3 || cmd_argc == 4'd6))); // R6

    AST_NO_SKIP_EMIT: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_op != 8'd13 && cmd_op != 8'd14)); // R8

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
        parse_err |-> (!cmd_valid && !mem_req)); // R9

    AST_WB_TARGET: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_req && mem_addr == ADDR_W'(HDR_CONS))); // R10

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) &&
                                      $stable(cmd_argc) && $stable(cmd_args))); // R11
endmodule

bind cmdring_parser cmdq_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_argc  (cmd_argc),
    .cmd_args  (cmd_args),
    .parse_err (parse_err)
);

// File: tb/cmdring_parser_bench.sv
module cmdring_parser_bench;
    localparam int AW = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_done = 1'b0;
    logic         cfg_enable = 1'b0;
    logic         mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]  mem_wdata;
    logic         mem_ack = 1'b0;
    logic [31:0]  mem_rdata = '0;
    logic         cmd_valid;
    logic         cmd_ready = 1'b0;
    logic [7:0]   cmd_op;
    logic [3:0]   cmd_argc;
    logic [191:0] cmd_args;
    logic         parse_err;

    always #5 clk = ~clk;

    cmdring_parser #(.ADDR_W(AW)) u_cmdring_parser (
        .clk(clk), .rst(rst), .cfg_done(cfg_done), .cfg_enable(cfg_enable),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_argc(cmd_argc), .cmd_args(cmd_args), .parse_err(parse_err)
    );

    logic [31:0] mem [0:63];
    int n_cmp = 0;
    int n_bad = 0;
    int req_seen = 0;
    int wb_count = 0;
    int ptr_w = 16;
    int cur_lo = 16;
    int cur_hi = 256;
    bit hold_low = 1'b1;
    int rcnt = 0;

    logic [7:0]   exp_op[$];
    logic [3:0]   exp_argc[$];
    logic [191:0] exp_args[$];
    string        exp_tag[$];

    task automatic chk(input bit ok, input string tag, input logic [191:0] act, input logic [191:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory responder: one wait cycle, then acknowledge
    initial begin
        forever begin
            @(posedge clk);
            if (mem_req) req_seen++;
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr] = mem_wdata;
                    wb_count++;
                end else begin
                    mem_rdata <= mem[mem_addr];
                end
            end else begin
                mem_ack <= 1'b0;
            end
        end
    end

    // downstream ready with periodic stalls
    initial begin
        forever begin
            @(posedge clk);
            rcnt++;
            cmd_ready <= hold_low ? 1'b0 : ((rcnt % 3) != 1);
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && cmd_valid && cmd_ready) begin
                if (exp_op.size() == 0) begin
                    chk(1'b0, "R5 unexpected command", {176'd0, cmd_op, 4'd0, cmd_argc}, '0);
                end else begin
                    logic [7:0] eo; logic [3:0] ea; logic [191:0] eg; string et;
                    eo = exp_op.pop_front(); ea = exp_argc.pop_front();
                    eg = exp_args.pop_front(); et = exp_tag.pop_front();
                    chk(cmd_op == eo && cmd_argc == ea && cmd_args == eg, et,
                        {cmd_op, cmd_argc, cmd_args[179:0]}, {eo, ea, eg[179:0]});
                end
            end
        end
    end

    task automatic put_word(input logic [31:0] w);
        mem[ptr_w / 4] = w;
        ptr_w += 4;
        if (ptr_w >= cur_hi) ptr_w = cur_lo;
    endtask

    task automatic publish();
        mem[2] = 32'(ptr_w);
    endtask

    task automatic emit(input logic [7:0] op, input int argc, input logic [31:0] a0, a1, a2, a3, a4, a5, input string tag);
        logic [191:0] v;
        v = {a5, a4, a3, a2, a1, a0};
        for (int i = argc; i < 6; i++) v[i*32 +: 32] = '0;
        put_word({24'd0, op});
        for (int i = 0; i < argc; i++) put_word(v[i*32 +: 32]);
        exp_op.push_back(op); exp_argc.push_back(4'(argc));
        exp_args.push_back(v); exp_tag.push_back(tag);
    endtask

    task automatic skip_cmd(input logic [31:0] op, input int n);
        put_word(op);
        for (int i = 0; i < n; i++) put_word(32'hDEAD_0000 + 32'(i));
    endtask

    task automatic setup(input int lo, input int hi, input int start);
        cur_lo = lo; cur_hi = hi; ptr_w = start;
        mem[0] = 32'(lo); mem[1] = 32'(hi); mem[2] = 32'(start); mem[3] = 32'(start);
    endtask

    task automatic wait_drain(input string tag);
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (exp_op.size() == 0 && mem[3] == 32'(ptr_w)) break;
        end
        chk(mem[3] == 32'(ptr_w) && exp_op.size() == 0, tag, mem[3], 192'(ptr_w));
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!cmd_valid && !mem_req && !parse_err, "R1 reset outputs",
            {cmd_valid, mem_req, parse_err}, '0);

        setup(16, 256, 16);
        emit(8'd1, 4, 32'd10, 32'd20, 32'd30, 32'd40, 0, 0, "R5 update");
        publish();
        cfg_done = 1'b1; cfg_enable = 1'b0;
        repeat (20) @(negedge clk);
        cfg_done = 1'b0; cfg_enable = 1'b1;
        repeat (20) @(negedge clk);
        chk(req_seen == 0, "R2 no access while off", 192'(req_seen), '0);
        chk(exp_op.size() == 1, "R2 nothing emitted while off", 192'(exp_op.size()), 192'd1);

        hold_low = 1'b0;
        cfg_done = 1'b1;
        emit(8'd25, 4, 32'd1, 32'd2, 32'd3, 32'd4, 0, 0, "R5 verbose update");
        emit(8'd2, 5, 32'hFF00FF, 32'd5, 32'd6, 32'd7, 32'd8, 0, "R6 fill");
        emit(8'd3, 6, 32'd11, 32'd12, 32'd13, 32'd14, 32'd15, 32'd16, "R6 copy");
        publish();
        wait_drain("R10 write-back after batch");

        begin
            int wb0;
            wb0 = wb_count;
            repeat (40) @(negedge clk);
            chk(wb_count == wb0, "R3 no write-back while empty", 192'(wb_count), 192'(wb0));
            chk(mem[3] == 32'(ptr_w), "R3 consumer unchanged", mem[3], 192'(ptr_w));
        end

        skip_cmd(32'd13, 6);
        skip_cmd(32'd14, 7);
        emit(8'd1, 4, 32'h31, 32'h32, 32'h33, 32'h34, 0, 0, "R8 update after skips");
        publish();
        wait_drain("R8 skipped commands consumed");

        emit(8'd19, 6, 32'd7, 32'd3, 32'd4, 32'd40, 32'd2, 32'd8, "R7 cursor header");
        for (int i = 0; i < (((40 + 31) / 32) * 2 + ((40 * 8 + 31) / 32) * 2); i++)
            put_word(32'hC000_0000 + 32'(i));
        emit(8'd1, 4, 32'h71, 32'h72, 32'h73, 32'h74, 0, 0, "R7 update after trailer");
        publish();
        wait_drain("R4 trailer across wrap");

        hold_low = 1'b1;
        emit(8'd2, 5, 32'hABCD, 32'd1, 32'd2, 32'd3, 32'd4, 0, "R11 held fill");
        publish();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (cmd_valid) break;
        end
        begin
            int wb0;
            wb0 = wb_count;
            repeat (20) @(negedge clk);
            chk(cmd_valid == 1'b1, "R11 valid held", {191'd0, cmd_valid}, 192'd1);
            chk(wb_count == wb0, "R11 parsing stalled", 192'(wb_count), 192'(wb0));
        end
        hold_low = 1'b0;
        wait_drain("R11 released");

        cfg_done = 1'b0; cfg_enable = 1'b0;
        repeat (30) @(negedge clk);
        setup(32, 128, 108);
        cfg_done = 1'b1; cfg_enable = 1'b1;
        emit(8'd1, 4, 32'h51, 32'h52, 32'h53, 32'h54, 0, 0, "R4 update ending at bound");
        publish();
        wait_drain("R4 wrap to lower bound");
        chk(mem[3] == 32'd32, "R4 wrapped consumer", mem[3], 192'd32);
        emit(8'd2, 5, 32'h9, 32'hA, 32'hB, 32'hC, 32'hD, 0, "R4 fill from lower bound");
        publish();
        wait_drain("R4 after wrap");
        chk(mem[3] == 32'd56, "R4 consumer advance", mem[3], 192'd56);

        put_word(32'd7);
        put_word(32'd1); put_word(32'd1); put_word(32'd2); put_word(32'd3); put_word(32'd4);
        publish();
        repeat (40) @(negedge clk);
        chk(parse_err == 1'b1, "R9 error raised", {191'd0, parse_err}, 192'd1);
        chk(mem[3] == 32'd56, "R9 consumer not written", mem[3], 192'd56);
        cfg_done = 1'b0;
        repeat (10) @(negedge clk);
        setup(32, 128, 32);
        cfg_done = 1'b1;
        repeat (10) @(negedge clk);
        chk(parse_err == 1'b0, "R9 cleared on re-enable", {191'd0, parse_err}, '0);
        emit(8'd1, 4, 32'h61, 32'h62, 32'h63, 32'h64, 0, 0, "R9 update after recovery");
        publish();
        wait_drain("R9 resumed");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule